// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit is the multiply/divide side of a 32-bit RISC integer core. It reads the raw instruction word and decodes the special-class arithmetic operations itself. Those are signed and unsigned multiply, signed divide, and the four moves between the general registers and the two result registers HI and LO. The pipeline supplies the instruction word, an issue strobe and the values of the two source registers. For a move-from, the unit returns a write-back value together with the destination register index.

Multiplies finish in the cycle they are accepted. A divide runs as a restoring shift-subtract loop that produces one quotient bit per cycle. The divider has three states. DV_IDLE waits for a divide. Its transition "start" leads to DV_RUN, which does one shift-subtract step per cycle. The transition "last step" leaves DV_RUN after the final bit and enters DV_FIX, which corrects the signs of quotient and remainder and writes LO and HI. The transition "commit" then returns to DV_IDLE.

While the divider is out of DV_IDLE, the unit raises `stall_o` against every legal operation presented. The pipeline holds that operation until the stall drops, so a move cannot read stale results and a move-to cannot be overwritten by the divide. Encodings with a nonzero reserved field are dropped and reported on `illegal_o`.

Top module: `hilo_muldiv`

## Requirements
- R1: An instruction takes part only when bits 31-26 are zero and bits 5-0 equal 16 (move-from-HI), 17 (move-to-HI), 18 (move-from-LO), 19 (move-to-LO), 24 (signed multiply), 25 (unsigned multiply) or 26 (signed divide). Any other word changes neither HI, LO nor any output.
- R2: An accepted move-to-HI or move-to-LO writes `rs_val_i` into HI or LO at the accepting clock edge. A move-from issued in the very next cycle returns the new value.
- R3: An accepted move-from-HI or move-from-LO sets `wb_valid_o` for one cycle, starting at the clock edge that accepts it. In that cycle `wb_data_o` holds HI or LO and `wb_dest_o` holds bits 15-11 of the instruction.
- R4: Code 24 writes the 64-bit two's-complement product of `rs_val_i` and `rt_val_i`, high half to HI and low half to LO. Code 25 does the same with both operands taken as unsigned. Both results are readable from the next cycle.
- R5: Code 26 leaves the quotient of `rs_val_i` / `rt_val_i`, truncated toward zero, in LO. It leaves the remainder, which carries the dividend's sign, in HI. The case -2^31 / -1 gives LO = 0x80000000 and HI = 0.
- R6: `busy_o` is high in the issue cycle of a divide and in the 33 cycles after it, 34 cycles in all. A move-from issued in the first cycle with `busy_o` low sees the final quotient and remainder.
- R7: While a divide is in progress after its issue cycle, any legal operation presented raises `stall_o` in that same cycle and has no effect. Once `stall_o` drops, the held operation executes normally, and a move-from then returns the finished divide result.
- R8: A move-to presented during a divide and held through the stall is not overwritten by the divide. After completion, that register holds the moved value and the other register holds the divide result.
- R9: A divide by zero keeps the same 34-cycle busy window and then accepts new work.
- R10: Some fields must be zero: bits 20-6 for a move-to, bits 25-16 and 10-6 for a move-from, and bits 15-6 for multiply and divide. If any of them is nonzero, the operation has no effect and `illegal_o` is high for exactly the one cycle after the issue cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the register named in bits 25-21 |
| rt_val_i | input | 32 | Value of the register named in bits 20-16 |
| wb_valid_o | output | 1 | Move-from result valid |
| wb_data_o | output | 32 | Move-from result |
| wb_dest_o | output | 5 | Destination register index for the result |
| busy_o | output | 1 | Divide in progress, issue cycle included |
| stall_o | output | 1 | The presented operation was not accepted and must be held |
| illegal_o | output | 1 | A reserved field was nonzero one cycle earlier |

## Verification
Inputs are driven on the falling edge and outputs are read on the next falling edge, after exactly one rising edge. Move-from results and `illegal_o` are therefore checked in the first sample after the issue. The effects of multiplies and moves-to are checked by a move-from issued in the next cycle. `stall_o` depends combinationally on the presented operation, so it is sampled in the cycle the operation is presented. The divide window is counted by sampling `busy_o` once per cycle from the issue cycle onward, and 34 samples are expected. Results are only read back in the first cycle with `busy_o` low, or through an operation held by the stall.

// File: rtl/hilo_mdu_pkg.sv
package hilo_mdu_pkg;

    localparam logic [5:0] FN_MFHI  = 6'd16;
    localparam logic [5:0] FN_MTHI  = 6'd17;
    localparam logic [5:0] FN_MFLO  = 6'd18;
    localparam logic [5:0] FN_MTLO  = 6'd19;
    localparam logic [5:0] FN_MULT  = 6'd24;
    localparam logic [5:0] FN_MULTU = 6'd25;
    localparam logic [5:0] FN_DIV   = 6'd26;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_MFHI,
        OP_MTHI,
        OP_MFLO,
        OP_MTLO,
        OP_MULT,
        OP_MULTU,
        OP_DIV
    } mdu_op_e;

    typedef enum logic [1:0] {
        DV_IDLE,
        DV_RUN,
        DV_FIX
    } div_state_e;

endpackage

// File: rtl/hilo_mdu_decode.sv
module hilo_mdu_decode
    import hilo_mdu_pkg::*;
(
    input  logic [31:0] instr_i,
    output mdu_op_e     op_o,
    output logic        reserved_bad_o,
    output logic [4:0]  dest_o
);

    logic [5:0] opcode;
    logic [5:0] fn;

    assign opcode = instr_i[31:26];
    assign fn     = instr_i[5:0];
    assign dest_o = instr_i[15:11];

    always_comb begin
        op_o           = OP_NONE;
        reserved_bad_o = 1'b0;
        if (opcode == 6'd0) begin
            case (fn)
                FN_MFHI: begin
                    op_o           = OP_MFHI;
                    reserved_bad_o = (|instr_i[25:16]) | (|instr_i[10:6]);
                end
                FN_MFLO: begin
                    op_o           = OP_MFLO;
                    reserved_bad_o = (|instr_i[25:16]) | (|instr_i[10:6]);
                end
                FN_MTHI: begin
                    op_o           = OP_MTHI;
                    reserved_bad_o = |instr_i[20:6];
                end
                FN_MTLO: begin
                    op_o           = OP_MTLO;
                    reserved_bad_o = |instr_i[20:6];
                end
                FN_MULT: begin
                    op_o           = OP_MULT;
                    reserved_bad_o = |instr_i[15:6];
                end
                FN_MULTU: begin
                    op_o           = OP_MULTU;
                    reserved_bad_o = |instr_i[15:6];
                end
                FN_DIV: begin
                    op_o           = OP_DIV;
                    reserved_bad_o = |instr_i[15:6];
                end
                default: begin
                    op_o           = OP_NONE;
                    reserved_bad_o = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/hilo_mdu_mult.sv
module hilo_mdu_mult #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           signed_i,
    output logic [2*W-1:0] prod_o
);

    localparam int PW = 2 * W;

    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;

    // Extension to full width makes the truncated product correct for both forms.
    assign a_ext  = {{W{signed_i & a_i[W-1]}}, a_i};
    assign b_ext  = {{W{signed_i & b_i[W-1]}}, b_i};
    assign prod_o = a_ext * b_ext;

endmodule

// File: rtl/hilo_mdu_divider.sv
module hilo_mdu_divider
    import hilo_mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    div_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dsr_q;
    logic          neg_q_q;
    logic          neg_r_q;

    logic [W:0]    shifted;
    logic [W:0]    diff;
    logic          take;
    logic          a_neg;
    logic          b_neg;
    logic [W-1:0]  mag_a;
    logic [W-1:0]  mag_b;

    assign a_neg   = dividend_i[W-1];
    assign b_neg   = divisor_i[W-1];
    assign mag_a   = a_neg ? ('0 - dividend_i) : dividend_i;
    assign mag_b   = b_neg ? ('0 - divisor_i) : divisor_i;

    assign shifted = {rem_q, quo_q[W-1]};
    assign diff    = shifted - {1'b0, dsr_q};
    assign take    = ~diff[W];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DV_IDLE: if (start_i) state_d = DV_RUN;
            DV_RUN:  if (cnt_q == LAST_STEP) state_d = DV_FIX;
            DV_FIX:  state_d = DV_IDLE;
            default: state_d = DV_IDLE;
        endcase
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rem_q   <= '0;
            quo_q   <= '0;
            dsr_q   <= '0;
            neg_q_q <= 1'b0;
            neg_r_q <= 1'b0;
        end else begin
            unique case (state_q)
                DV_IDLE: begin
                    if (start_i) begin
                        cnt_q   <= '0;
                        rem_q   <= '0;
                        quo_q   <= mag_a;
                        dsr_q   <= mag_b;
                        neg_q_q <= a_neg ^ b_neg;
                        neg_r_q <= a_neg;
                    end
                end
                DV_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (take) begin
                        rem_q <= diff[W-1:0];
                    end else begin
                        rem_q <= shifted[W-1:0];
                    end
                    quo_q <= {quo_q[W-2:0], take};
                end
                DV_FIX: begin
                    cnt_q <= '0;
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o = (state_q != DV_IDLE);
        done_o = (state_q == DV_FIX);
        quo_o  = neg_q_q ? ('0 - quo_q) : quo_q;
        rem_o  = neg_r_q ? ('0 - rem_q) : rem_q;
    end

    // R6: a new divide is only started from the idle state
    a_r6_start_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> state_q == DV_IDLE);

    // R9: the commit cycle is always followed by an idle divider
    a_r9_done_then_free : assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R6: the run phase is entered only from the cycle after a start
    a_r6_run_after_start : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
    import hilo_mdu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [XLEN-1:0] rt_val_i,
    output logic            wb_valid_o,
    output logic [XLEN-1:0] wb_data_o,
    output logic [4:0]      wb_dest_o,
    output logic            busy_o,
    output logic            stall_o,
    output logic            illegal_o
);

    localparam int PW = 2 * XLEN;

    mdu_op_e        op;
    logic           reserved_bad;
    logic [4:0]     dest;
    logic           legal;
    logic           accept;
    logic           div_start;
    logic           div_busy;
    logic           div_done;
    logic [XLEN-1:0] div_quo;
    logic [XLEN-1:0] div_rem;
    logic [PW-1:0]  prod;

    logic [XLEN-1:0] hi_q;
    logic [XLEN-1:0] lo_q;
    logic            wb_valid_q;
    logic [XLEN-1:0] wb_data_q;
    logic [4:0]      wb_dest_q;
    logic            illegal_q;

    hilo_mdu_decode u_decode (
        .instr_i        (instr_i),
        .op_o           (op),
        .reserved_bad_o (reserved_bad),
        .dest_o         (dest)
    );

    hilo_mdu_mult #(.W(XLEN)) u_mult (
        .a_i      (rs_val_i),
        .b_i      (rt_val_i),
        .signed_i (op == OP_MULT),
        .prod_o   (prod)
    );

    hilo_mdu_divider #(.W(XLEN)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (rs_val_i),
        .divisor_i  (rt_val_i),
        .busy_o     (div_busy),
        .done_o     (div_done),
        .quo_o      (div_quo),
        .rem_o      (div_rem)
    );

    assign legal     = issue_i && (op != OP_NONE) && !reserved_bad;
    assign accept    = legal && !div_busy;
    assign div_start = accept && (op == OP_DIV);

    // HI/LO registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (div_done) begin
            hi_q <= div_rem;
            lo_q <= div_quo;
        end else if (accept) begin
            unique case (op)
                OP_MTHI:  hi_q <= rs_val_i;
                OP_MTLO:  lo_q <= rs_val_i;
                OP_MULT,
                OP_MULTU: begin
                    hi_q <= prod[PW-1:XLEN];
                    lo_q <= prod[XLEN-1:0];
                end
                default: begin
                    hi_q <= hi_q;
                    lo_q <= lo_q;
                end
            endcase
        end
    end

    // Write-back and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid_q <= 1'b0;
            wb_data_q  <= '0;
            wb_dest_q  <= '0;
            illegal_q  <= 1'b0;
        end else begin
            wb_valid_q <= accept && ((op == OP_MFHI) || (op == OP_MFLO));
            if (accept && (op == OP_MFHI)) begin
                wb_data_q <= hi_q;
                wb_dest_q <= dest;
            end else if (accept && (op == OP_MFLO)) begin
                wb_data_q <= lo_q;
                wb_dest_q <= dest;
            end
            illegal_q <= issue_i && (op != OP_NONE) && reserved_bad;
        end
    end

    assign wb_valid_o = wb_valid_q;
    assign wb_data_o  = wb_data_q;
    assign wb_dest_o  = wb_dest_q;
    assign illegal_o  = illegal_q;
    assign busy_o     = div_busy | div_start;
    assign stall_o    = legal && div_busy;

    // R7: a stall is only ever raised while the divider runs
    a_r7_stall_needs_busy : assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> busy_o);

    // R8: HI and LO do not move while the divide is in its run phase
    a_r8_hilo_frozen : assert property (@(posedge clk) disable iff (!rst_n)
        (div_busy && !div_done) |=> ($stable(hi_q) && $stable(lo_q)));

    // R3: a write-back follows an issue made while the divider was free
    a_r3_wb_after_issue : assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> ($past(issue_i) && !$past(div_busy)));

    // R10: the illegal flag follows an issue and never comes with a write-back
    a_r10_illegal_alone : assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> ($past(issue_i) && !wb_valid_o));

endmodule

// File: tb/hilo_muldiv_tb.sv
module hilo_muldiv_tb;

    logic        clk;
    logic        rst_n;
    logic        issue;
    logic [31:0] instr;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic        wb_valid;
    logic [31:0] wb_data;
    logic [4:0]  wb_dest;
    logic        busy;
    logic        stall;
    logic        illegal;

    int checks;
    int errors;
    logic [31:0] m_hi;
    logic [31:0] m_lo;

    hilo_muldiv u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_i    (issue),
        .instr_i    (instr),
        .rs_val_i   (rs_val),
        .rt_val_i   (rt_val),
        .wb_valid_o (wb_valid),
        .wb_data_o  (wb_data),
        .wb_dest_o  (wb_dest),
        .busy_o     (busy),
        .stall_o    (stall),
        .illegal_o  (illegal)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic logic [31:0] enc_mt(input logic [5:0] fn, input logic [4:0] rs);
        return {6'd0, rs, 15'd0, fn};
    endfunction

    function automatic logic [31:0] enc_mf(input logic [5:0] fn, input logic [4:0] rd);
        return {6'd0, 10'd0, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_md(input logic [5:0] fn);
        return {6'd0, 5'd4, 5'd5, 10'd0, fn};
    endfunction

    function automatic logic [63:0] exp_mul(input logic [31:0] a, input logic [31:0] b,
                                            input logic sgn);
        longint sa;
        longint sb;
        if (sgn) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
        end else begin
            sa = longint'({32'd0, a});
            sb = longint'({32'd0, b});
        end
        return 64'(sa * sb);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic send(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        issue  = 1'b1;
        instr  = ins;
        rs_val = a;
        rt_val = b;
        @(negedge clk);
        issue  = 1'b0;
        instr  = 32'h0;
    endtask

    task automatic read_hilo(input string req);
        send(enc_mf(6'd16, 5'd3), 32'h0, 32'h0);
        chk(wb_valid && wb_dest == 5'd3 && wb_data == m_hi, req, wb_data, m_hi);
        send(enc_mf(6'd18, 5'd17), 32'h0, 32'h0);
        chk(wb_valid && wb_dest == 5'd17 && wb_data == m_lo, req, wb_data, m_lo);
    endtask

    task automatic run_div(input logic [31:0] a, input logic [31:0] b, input string req);
        int n;
        longint q;
        longint r;
        @(negedge clk);
        issue  = 1'b1;
        instr  = enc_md(6'd26);
        rs_val = a;
        rt_val = b;
        #1;
        n = busy ? 1 : 0;
        @(negedge clk);
        issue = 1'b0;
        instr = 32'h0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == 34, "R6 busy window", 32'(n), 32'd34);
        if (b != 32'd0) begin
            q = longint'($signed(a)) / longint'($signed(b));
            r = longint'($signed(a)) % longint'($signed(b));
            m_lo = q[31:0];
            m_hi = r[31:0];
            read_hilo(req);
        end
    endtask

    // Watchdog
    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] p;
        int n;
        checks = 0;
        errors = 0;
        void'($urandom(32'd2024));
        issue  = 1'b0;
        instr  = 32'h0;
        rs_val = 32'h0;
        rt_val = 32'h0;
        rst_n  = 1'b0;
        m_hi   = 32'h0;
        m_lo   = 32'h0;
        repeat (3) @(negedge clk);
        chk(!wb_valid && !busy && !illegal, "reset outputs", {29'd0, wb_valid, busy, illegal}, 32'd0);
        rst_n = 1'b1;
        read_hilo("reset HI/LO");

        // R2 move-to
        send(enc_mt(6'd17, 5'd9), 32'hDEAD_BEEF, 32'h0);
        m_hi = 32'hDEAD_BEEF;
        send(enc_mt(6'd19, 5'd2), 32'h1234_5678, 32'h0);
        m_lo = 32'h1234_5678;
        read_hilo("R2 move-to");

        // R1 foreign opcode and unknown function
        send({6'd8, 5'd0, 15'd0, 6'd17}, 32'h5555_5555, 32'h0);
        send({26'd0, 6'd20}, 32'h6666_6666, 32'h0);
        chk(!illegal && !wb_valid, "R1 ignored flags", {30'd0, illegal, wb_valid}, 32'd0);
        read_hilo("R1 ignored");

        // R4 multiplies
        send(enc_md(6'd24), 32'hFFFF_FFFD, 32'd7);
        p = exp_mul(32'hFFFF_FFFD, 32'd7, 1'b1);
        m_hi = p[63:32]; m_lo = p[31:0];
        read_hilo("R4 signed mult");
        send(enc_md(6'd25), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        p = exp_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        m_hi = p[63:32]; m_lo = p[31:0];
        read_hilo("R4 unsigned mult");

        // R5 directed divides
        run_div(32'hFFFF_FFE1, 32'd4, "R5 neg dividend");
        run_div(32'd100, 32'hFFFF_FFF9, "R5 neg divisor");
        run_div(32'h8000_0000, 32'hFFFF_FFFF, "R5 min over minus one");
        chk(m_lo == 32'h8000_0000 && m_hi == 32'h0, "R5 min case model", m_lo, 32'h8000_0000);

        // R9 divide by zero
        run_div(32'd77, 32'd0, "R9 zero divisor");
        send(enc_mt(6'd17, 5'd1), 32'hA5A5_0001, 32'h0);
        send(enc_mt(6'd19, 5'd1), 32'h0000_5A5A, 32'h0);
        m_hi = 32'hA5A5_0001; m_lo = 32'h0000_5A5A;
        read_hilo("R9 accepts after zero divide");

        // R7 move-from held during divide
        @(negedge clk);
        issue = 1'b1; instr = enc_md(6'd26); rs_val = 32'd1000; rt_val = 32'd33;
        @(negedge clk);
        instr = enc_mf(6'd16, 5'd8);
        #1;
        chk(stall && busy, "R7 stall raised", {30'd0, stall, busy}, 32'd3);
        n = 0;
        while (stall && n < 100) begin
            @(negedge clk);
            chk(!wb_valid, "R7 no write-back while held", {31'd0, wb_valid}, 32'd0);
            #1;
            n++;
        end
        @(negedge clk);
        issue = 1'b0; instr = 32'h0;
        chk(wb_valid && wb_dest == 5'd8 && wb_data == 32'd10, "R7 held move-from", wb_data, 32'd10);
        m_hi = 32'd10; m_lo = 32'd30;

        // R8 move-to held during divide
        @(negedge clk);
        issue = 1'b1; instr = enc_md(6'd26); rs_val = 32'hFFFF_FF38; rt_val = 32'd7;
        @(negedge clk);
        instr = enc_mt(6'd17, 5'd6); rs_val = 32'hCAFE_F00D;
        #1;
        chk(stall, "R8 move-to stalled", {31'd0, stall}, 32'd1);
        n = 0;
        while (stall && n < 100) begin
            @(negedge clk);
            #1;
            n++;
        end
        @(negedge clk);
        issue = 1'b0; instr = 32'h0;
        m_hi = 32'hCAFE_F00D; m_lo = 32'hFFFF_FFE4;
        read_hilo("R8 move-to survives divide");

        // R10 reserved fields
        send(enc_mt(6'd17, 5'd2) | 32'h0000_0400, 32'h1111_1111, 32'h0);
        chk(illegal, "R10 flag move-to", {31'd0, illegal}, 32'd1);
        @(negedge clk);
        chk(!illegal, "R10 one-cycle flag", {31'd0, illegal}, 32'd0);
        send(enc_mf(6'd18, 5'd4) | 32'h0001_0000, 32'h0, 32'h0);
        chk(illegal && !wb_valid, "R10 flag move-from", {30'd0, illegal, wb_valid}, 32'd2);
        send(enc_md(6'd24) | 32'h0000_0040, 32'd3, 32'd3);
        chk(illegal && !busy, "R10 flag multiply", {30'd0, illegal, busy}, 32'd2);
        read_hilo("R10 no effect");

        // Constrained random
        for (int i = 0; i < 120; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            int sel;
            a = $urandom;
            b = $urandom;
            if ($urandom % 4 == 0) b = b % 16;
            if ($urandom % 8 == 0) a = 32'h8000_0000;
            sel = $urandom % 5;
            case (sel)
                0: begin send(enc_mt(6'd17, 5'(i)), a, b); m_hi = a; read_hilo("R2 random"); end
                1: begin send(enc_mt(6'd19, 5'(i)), a, b); m_lo = a; read_hilo("R2 random"); end
                2: begin
                    send(enc_md(6'd24), a, b);
                    p = exp_mul(a, b, 1'b1); m_hi = p[63:32]; m_lo = p[31:0];
                    read_hilo("R4 random signed");
                end
                3: begin
                    send(enc_md(6'd25), a, b);
                    p = exp_mul(a, b, 1'b0); m_hi = p[63:32]; m_lo = p[31:0];
                    read_hilo("R4 random unsigned");
                end
                default: begin
                    if (b == 32'd0) b = 32'd3;
                    run_div(a, b, "R5 random divide");
                end
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule